// File: doc/BRIEF.md
# Tape write record transmitter

This block puts one record onto a tape drive's write bus. A start pulse launches the record. The mode input chooses between a data record and a filemark. For the command, the block pulls the write line low together with a GO pulse of at least one microsecond, and it also pulls the filemark line low when the filemark mode is chosen. Bytes come in on a valid/ready stream. The stream carries a marker on the byte that ends the record.

The bus has no acknowledge. The block therefore keeps the current byte on the active-low data lines until the drive's write strobe has sampled it. The byte is bit-reversed so that line 0 carries the most significant bit, and an odd-parity line goes with it. When the trailing edge of a strobe shows that the drive has taken the byte, the next byte is loaded into the holding register. When the end-of-record byte is loaded, the last-word line goes low, which gives it a full byte period of lead before the final strobe. If a strobe arrives while the holding register is empty, a sticky underrun flag is set.

The record ends when the busy line that the block watches returns high. For a data record this is data-busy, and for a filemark it is formatter-busy. At that point every bus line goes back to its released level. All drive inputs pass through synchronizers before the block uses them.

Top module: `tape_wr_xmit`

## Requirements
- R1: After reset, every active-low output (wd_n, wp_n, lwd_n, go_n, wrt_n, wfm_n) is 1, underrun is 0 and in_ready is 0.
- R2: A start pulse in idle drives go_n low for exactly GO_CYC clock cycles, where GO_CYC = ceil(GO_NS/CLK_NS). wrt_n is driven low from that point until the record completes.
- R3: While a byte is held, wd_n[j] equals the inverse of byte bit (7-j), so wd_n[0] carries the inverted MSB.
- R4: wp_n is 0 (parity asserted) exactly when the held byte has an even number of ones, which makes the total count of asserted bits odd.
- R5: A held byte stays on the lines until the trailing (rising) edge of wstr_n. in_ready is 1 only during a data record, while the holding register is empty and before the end-of-record byte has been taken. No byte is accepted after the end-of-record byte.
- R6: lwd_n goes low when the byte marked in_last is loaded. It stays high for all earlier bytes of the record.
- R7: A falling edge of wstr_n while the holding register is empty during a data record sets underrun. underrun stays set through record completion and clears on the next start.
- R8: For a data record, a rising edge of dbusy_n after it has been seen low completes the record. wd_n returns to all ones, and wp_n, lwd_n and wrt_n return to 1.
- R9: With mode_fmk=1, wfm_n is low together with wrt_n, no byte is accepted (in_ready stays 0), and the record completes on a rising edge of fbusy_n after it has been seen low.
- R10: lwd_n is low for at least LEAD_CYC = ceil(LEAD_NS/CLK_NS) cycles before the trailing edge of the final strobe is acted on, provided the drive keeps its normal byte period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that launches a record when idle |
| mode_fmk | input | 1 | 1 = write a filemark, 0 = write a data record |
| in_data | input | DATA_W | Byte from the input stream |
| in_valid | input | 1 | Stream byte available |
| in_last | input | 1 | Byte ends the record |
| in_ready | output | 1 | Block accepts the byte this cycle |
| wstr_n | input | 1 | Drive write strobe, active low |
| dbusy_n | input | 1 | Drive data busy, active low |
| fbusy_n | input | 1 | Drive formatter busy, active low |
| wd_n | output | DATA_W | Write data lines, active low, line 0 = MSB |
| wp_n | output | 1 | Write parity line, active low, odd parity |
| lwd_n | output | 1 | Last-word line, active low |
| go_n | output | 1 | GO command pulse, active low |
| wrt_n | output | 1 | Write command line, active low |
| wfm_n | output | 1 | Write-filemark line, active low |
| underrun | output | 1 | Sticky flag: a strobe found no byte waiting |

## Verification
The hardest condition to reach is an underrun. The stream must be starved at the very moment a strobe edge gets through the synchronizer, and a normal source never lets that happen. The bench holds the source's enable low while the drive model strobes. It then checks that the flag survives record completion and clears on the next start. Two other checks depend on timing that a normal source hides. The first is the lead of last-word: the bench counts the cycles it is low before the final trailing edge. The second is the refusal of an extra byte offered after the end-of-record byte: the stream index must stop at the record length.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_GO, ST_RUN} tw_state_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], d[g]};
    end
    assign q[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/tw_seq.sv
module tw_seq
  import tw_pkg::*;
#(
  parameter int CLK_NS = 10,
  parameter int GO_NS  = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic mode_fmk,
  input  logic dbusy_s,
  input  logic fbusy_s,
  output logic go_n,
  output logic wrt_n,
  output logic wfm_n,
  output logic data_rec,
  output logic rec_start,
  output logic rec_done
);
  localparam int GO_RAW = ceil_div(GO_NS, CLK_NS);
  localparam int GO_CYC = (GO_RAW < 1) ? 1 : GO_RAW;
  localparam int CW     = $clog2(GO_CYC + 1);

  tw_state_e       state;
  logic [CW-1:0]   cnt;
  logic            fmk;
  logic            seen;
  logic            watch;

  assign watch     = fmk ? fbusy_s : dbusy_s;
  assign rec_start = (state == ST_IDLE) && start;
  assign rec_done  = (state == ST_RUN) && seen && watch;
  assign data_rec  = (state != ST_IDLE) && !fmk;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      fmk   <= 1'b0;
      seen  <= 1'b0;
      go_n  <= 1'b1;
      wrt_n <= 1'b1;
      wfm_n <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_GO;
          cnt   <= '0;
          fmk   <= mode_fmk;
          seen  <= 1'b0;
          go_n  <= 1'b0;
          wrt_n <= 1'b0;
          wfm_n <= !mode_fmk;
        end
        ST_GO: begin
          cnt <= cnt + 1'b1;
          if (!watch) seen <= 1'b1;
          if (cnt == CW'(GO_CYC - 1)) begin
            go_n  <= 1'b1;
            state <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (!watch) seen <= 1'b1;
          if (rec_done) begin
            wrt_n <= 1'b1;
            wfm_n <= 1'b1;
            fmk   <= 1'b0;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tw_hold.sv
module tw_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rec_start,
  input  logic              rec_done,
  input  logic              data_rec,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_last,
  input  logic              strobe_fall,
  input  logic              strobe_rise,
  output logic              in_ready,
  output logic [DATA_W-1:0] wd_n,
  output logic              wp_n,
  output logic              lwd_n,
  output logic              underrun,
  output logic              hold_full,
  output logic              last_taken,
  output logic              lines_on
);
  logic [DATA_W-1:0] enc;
  logic              load;

  for (genvar g = 0; g < DATA_W; g++) begin : g_rev
    assign enc[g] = ~in_data[DATA_W-1-g];
  end

  assign in_ready = data_rec && !hold_full && !last_taken;
  assign load     = in_ready && in_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_full  <= 1'b0;
      last_taken <= 1'b0;
      wd_n       <= '1;
      wp_n       <= 1'b1;
      lwd_n      <= 1'b1;
      underrun   <= 1'b0;
      lines_on   <= 1'b0;
    end else if (rec_done) begin
      hold_full  <= 1'b0;
      last_taken <= 1'b0;
      wd_n       <= '1;
      wp_n       <= 1'b1;
      lwd_n      <= 1'b1;
      lines_on   <= 1'b0;
    end else begin
      if (rec_start) begin
        underrun   <= 1'b0;
        last_taken <= 1'b0;
        hold_full  <= 1'b0;
      end
      if (load) begin
        hold_full <= 1'b1;
        wd_n      <= enc;
        wp_n      <= ^in_data;
        lines_on  <= 1'b1;
        if (in_last) begin
          last_taken <= 1'b1;
          lwd_n      <= 1'b0;
        end
      end else if (strobe_rise && hold_full) begin
        hold_full <= 1'b0;
      end
      if (strobe_fall && !hold_full && data_rec) underrun <= 1'b1;
    end
  end
endmodule

// File: rtl/tape_wr_xmit.sv
module tape_wr_xmit #(
  parameter int DATA_W      = 8,
  parameter int CLK_NS      = 10,
  parameter int GO_NS       = 1000,
  parameter int LEAD_NS     = 300,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              mode_fmk,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_last,
  output logic              in_ready,
  input  logic              wstr_n,
  input  logic              dbusy_n,
  input  logic              fbusy_n,
  output logic [DATA_W-1:0] wd_n,
  output logic              wp_n,
  output logic              lwd_n,
  output logic              go_n,
  output logic              wrt_n,
  output logic              wfm_n,
  output logic              underrun
);
  logic [2:0] sync_q;
  logic       wstr_s, dbusy_s, fbusy_s;
  logic       wstr_prev;
  logic       strobe_fall, strobe_rise;
  logic       data_rec, rec_start, rec_done;
  logic       hold_full, last_taken, lines_on;

  tw_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({fbusy_n, dbusy_n, wstr_n}), .q(sync_q)
  );
  assign wstr_s  = sync_q[0];
  assign dbusy_s = sync_q[1];
  assign fbusy_s = sync_q[2];

  always_ff @(posedge clk) begin
    if (rst) wstr_prev <= 1'b1;
    else     wstr_prev <= wstr_s;
  end
  assign strobe_fall = wstr_prev && !wstr_s;
  assign strobe_rise = !wstr_prev && wstr_s;

  tw_seq #(.CLK_NS(CLK_NS), .GO_NS(GO_NS)) u_seq (
    .clk(clk), .rst(rst), .start(start), .mode_fmk(mode_fmk),
    .dbusy_s(dbusy_s), .fbusy_s(fbusy_s),
    .go_n(go_n), .wrt_n(wrt_n), .wfm_n(wfm_n),
    .data_rec(data_rec), .rec_start(rec_start), .rec_done(rec_done)
  );

  tw_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .rec_start(rec_start), .rec_done(rec_done),
    .data_rec(data_rec), .in_data(in_data), .in_valid(in_valid),
    .in_last(in_last), .strobe_fall(strobe_fall), .strobe_rise(strobe_rise),
    .in_ready(in_ready), .wd_n(wd_n), .wp_n(wp_n), .lwd_n(lwd_n),
    .underrun(underrun), .hold_full(hold_full), .last_taken(last_taken),
    .lines_on(lines_on)
  );
endmodule

// File: rtl/tw_checker.sv
module tw_checker #(
  parameter int DATA_W  = 8,
  parameter int CLK_NS  = 10,
  parameter int GO_NS   = 1000,
  parameter int LEAD_NS = 300
) (
  input logic              clk,
  input logic              rst,
  input logic              go_n,
  input logic              wrt_n,
  input logic              wfm_n,
  input logic              lwd_n,
  input logic              wp_n,
  input logic [DATA_W-1:0] wd_n,
  input logic              in_ready,
  input logic              underrun,
  input logic              rec_start,
  input logic              rec_done,
  input logic              strobe_rise,
  input logic              hold_full,
  input logic              last_taken,
  input logic              lines_on
);
  localparam int GO_RAW   = tw_pkg::ceil_div(GO_NS, CLK_NS);
  localparam int GO_CYC   = (GO_RAW < 1) ? 1 : GO_RAW;
  localparam int LEAD_CYC = tw_pkg::ceil_div(LEAD_NS, CLK_NS);
  localparam int GW       = $clog2(GO_CYC + 2);
  localparam int LW       = $clog2(LEAD_CYC + 2);

  logic [GW-1:0] go_len;
  logic [LW-1:0] lead_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      go_len   <= '0;
      lead_cnt <= '0;
    end else begin
      if (!go_n) go_len <= go_len + 1'b1;
      else       go_len <= '0;
      if (lwd_n)                           lead_cnt <= '0;
      else if (lead_cnt != LW'(LEAD_CYC))  lead_cnt <= lead_cnt + 1'b1;
    end
  end

  p_go_width_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(go_n) |-> (go_len == GW'(GO_CYC)));

  p_odd_parity_r4: assert property (@(posedge clk) disable iff (rst)
    lines_on |-> (^{~wd_n, ~wp_n}));

  p_hold_stable_r5: assert property (@(posedge clk) disable iff (rst)
    (hold_full && !strobe_rise && !rec_done) |=> $stable(wd_n));

  p_underrun_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (underrun && !rec_start) |=> underrun);

  p_idle_lines_r8: assert property (@(posedge clk) disable iff (rst)
    wrt_n |-> (wd_n == '1 && wp_n && lwd_n && wfm_n));

  p_fmk_no_ready_r9: assert property (@(posedge clk) disable iff (rst)
    !wfm_n |-> !in_ready);

  p_lwd_lead_r10: assert property (@(posedge clk) disable iff (rst)
    (strobe_rise && hold_full && last_taken) |-> (lead_cnt >= LW'(LEAD_CYC)));
endmodule

bind tape_wr_xmit tw_checker #(
  .DATA_W(DATA_W), .CLK_NS(CLK_NS), .GO_NS(GO_NS), .LEAD_NS(LEAD_NS)
) u_chk (
  .clk(clk), .rst(rst), .go_n(go_n), .wrt_n(wrt_n), .wfm_n(wfm_n),
  .lwd_n(lwd_n), .wp_n(wp_n), .wd_n(wd_n), .in_ready(in_ready),
  .underrun(underrun), .rec_start(rec_start), .rec_done(rec_done),
  .strobe_rise(strobe_rise), .hold_full(hold_full),
  .last_taken(last_taken), .lines_on(lines_on)
);

// File: tb/tape_wr_xmit_test.sv
module tape_wr_xmit_test;
  localparam int CLK_NS   = 10;
  localparam int GO_NS    = 100;
  localparam int LEAD_NS  = 300;
  localparam int GO_CYC   = 10;
  localparam int LEAD_CYC = 30;
  localparam int GAP      = 30;

  logic clk = 0;
  logic rst = 1;
  logic start = 0, mode_fmk = 0;
  logic wstr_n = 1, dbusy_n = 1, fbusy_n = 1;
  logic [7:0] in_data;
  logic in_valid, in_last, in_ready;
  logic [7:0] wd_n;
  logic wp_n, lwd_n, go_n, wrt_n, wfm_n, underrun;

  int checks = 0, errors = 0;
  logic [7:0] src_data [0:511];
  logic       src_last [0:511];
  int idx = 0, n_src = 0, ready_cnt = 0, lwd_cnt = 0;
  logic src_en = 0, take = 0, finished = 0;

  always #5 clk = ~clk;

  assign in_valid = src_en && (idx < n_src);
  assign in_data  = src_data[idx[8:0]];
  assign in_last  = src_last[idx[8:0]];

  tape_wr_xmit #(.DATA_W(8), .CLK_NS(CLK_NS), .GO_NS(GO_NS), .LEAD_NS(LEAD_NS)) uut (
    .clk(clk), .rst(rst), .start(start), .mode_fmk(mode_fmk),
    .in_data(in_data), .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
    .wstr_n(wstr_n), .dbusy_n(dbusy_n), .fbusy_n(fbusy_n),
    .wd_n(wd_n), .wp_n(wp_n), .lwd_n(lwd_n), .go_n(go_n),
    .wrt_n(wrt_n), .wfm_n(wfm_n), .underrun(underrun)
  );

  always @(negedge clk) begin
    if (take) idx = idx + 1;
    take = src_en && (idx < n_src) && in_ready;
    if (in_ready) ready_cnt = ready_cnt + 1;
    if (!lwd_n) lwd_cnt = lwd_cnt + 1;
    else        lwd_cnt = 0;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_lines(input logic [7:0] b);
    logic [7:0] r;
    for (int j = 0; j < 8; j++) r[j] = ~b[7-j];
    return r;
  endfunction

  function automatic logic exp_par_n(input logic [7:0] b);
    int ones = 0;
    for (int j = 0; j < 8; j++) ones += int'(b[j]);
    return (ones % 2 == 0) ? 1'b0 : 1'b1;
  endfunction

  task automatic launch(input logic fmk);
    int cnt = 0;
    @(negedge clk); mode_fmk = fmk; start = 1;
    @(negedge clk); start = 0;
    while (go_n == 1'b0 && cnt < 1000) begin @(negedge clk); cnt++; end
    check(cnt == GO_CYC, "R2 go width", cnt, GO_CYC);
    check(wrt_n == 1'b0, "R2 wrt held", wrt_n, 0);
  endtask

  task automatic data_record(input int n, input int pat, input bit extra);
    int base;
    logic [7:0] b;
    base = idx;
    for (int i = 0; i < n + 1; i++) begin
      src_data[base+i] = (pat == 0) ? 8'(i) : 8'((i * 37 + 11) & 255);
      src_last[base+i] = (i == n - 1);
    end
    n_src = base + n + (extra ? 1 : 0);
    src_en = 1;
    launch(1'b0);
    check(wfm_n == 1'b1, "R9 wfm idle in data record", wfm_n, 1);
    dbusy_n = 0; fbusy_n = 0;
    repeat (5) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      b = src_data[base+i];
      repeat (GAP) @(negedge clk);
      wstr_n = 0;
      repeat (5) @(negedge clk);
      check(wd_n == exp_lines(b), "R3 data lines", wd_n, exp_lines(b));
      check(wp_n == exp_par_n(b), "R4 parity", wp_n, exp_par_n(b));
      check(lwd_n == ((i == n - 1) ? 1'b0 : 1'b1), "R6 last word", lwd_n, (i == n - 1) ? 0 : 1);
      repeat (4) @(negedge clk);
      check(wd_n == exp_lines(b), "R5 held until trailing edge", wd_n, exp_lines(b));
      if (i == n - 1) check(lwd_cnt >= LEAD_CYC, "R10 last-word lead", lwd_cnt, LEAD_CYC);
      @(negedge clk); wstr_n = 1;
    end
    repeat (10) @(negedge clk);
    check(idx == base + n, "R5 accepted count", idx - base, n);
    check(in_ready == 1'b0, "R5 no ready after last", in_ready, 0);
    dbusy_n = 1; fbusy_n = 1;
    repeat (8) @(negedge clk);
    check(wd_n == 8'hFF && wp_n && lwd_n && wrt_n, "R8 idle after done",
          {wd_n, wp_n, lwd_n, wrt_n}, 11'h7FF);
    src_en = 0;
    n_src = idx;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(wd_n == 8'hFF, "R1 reset wd_n", wd_n, 8'hFF);
    check({wp_n, lwd_n, go_n, wrt_n, wfm_n} == 5'b11111, "R1 reset controls",
          {wp_n, lwd_n, go_n, wrt_n, wfm_n}, 5'h1F);
    check(underrun == 0 && in_ready == 0, "R1 reset flags", {underrun, in_ready}, 0);
    rst = 0;
    repeat (3) @(negedge clk);

    data_record(256, 0, 1'b0);
    data_record(5, 1, 1'b1);
    data_record(1, 1, 1'b0);

    begin : fmk_case
      int r0, i0;
      src_data[idx] = 8'h5A; src_last[idx] = 1; n_src = idx + 1; src_en = 1;
      r0 = ready_cnt; i0 = idx;
      launch(1'b1);
      check(wfm_n == 1'b0, "R9 wfm asserted", wfm_n, 0);
      fbusy_n = 0;
      repeat (20) @(negedge clk);
      fbusy_n = 1;
      repeat (8) @(negedge clk);
      check(wfm_n == 1'b1 && wrt_n == 1'b1, "R9 filemark complete", {wfm_n, wrt_n}, 3);
      check(ready_cnt == r0 && idx == i0, "R9 no byte accepted", ready_cnt - r0, 0);
      src_en = 0; n_src = idx; mode_fmk = 0;
    end

    begin : under_case
      src_en = 0;
      launch(1'b0);
      dbusy_n = 0; fbusy_n = 0;
      repeat (5) @(negedge clk);
      wstr_n = 0;
      repeat (6) @(negedge clk);
      check(underrun == 1'b1, "R7 underrun set", underrun, 1);
      wstr_n = 1;
      repeat (6) @(negedge clk);
      dbusy_n = 1; fbusy_n = 1;
      repeat (8) @(negedge clk);
      check(underrun == 1'b1, "R7 underrun sticky", underrun, 1);
      check(wrt_n == 1'b1, "R8 done without data", wrt_n, 1);
      @(negedge clk); start = 1;
      @(negedge clk); start = 0;
      @(negedge clk);
      check(underrun == 1'b0, "R7 cleared by start", underrun, 0);
      repeat (GO_CYC + 5) @(negedge clk);
      dbusy_n = 0; repeat (5) @(negedge clk);
      dbusy_n = 1; repeat (8) @(negedge clk);
    end

    data_record(3, 0, 1'b1);

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule